// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block arbitrates interrupt requests for a single processor. Requests come from a set of level-sensitive hardware lines and from a small bank of software-triggered sources. Every source has its own programmable priority. A value of 0 disables the source. The block presents the best pending source to the processor whenever that source's priority is strictly above the current priority. It reports the source through `irq` and `vec_id`.

When the processor takes a request with `ack`, the block saves the running priority on a last-in first-out stack and adopts the taken source's priority. An end-of-interrupt write restores the saved priority. Because of this, a more urgent request can preempt a handler, and the older level returns when that handler completes.

The software sources are reachable through the shared register bus, so any bus master can start a handler on this processor. Each software source has a write-one trigger bit. It also has a pending flag that stays set until the handler clears it. A requester reads this flag to learn whether its earlier request has been serviced.

Top module: `prio_intc`

## Requirements
- R1: A write to address 2 with bit i set (i below NUM_SW) makes software source i pending. That source is arbitration index NUM_HW+i. Zero bits in that field change nothing.
- R2: Bits NUM_SW+i of address 2 read 1 while software source i is pending. Writing 1 there clears the flag and writing 0 leaves it alone. A single write that both triggers and clears a source leaves it pending. The trigger field always reads 0.
- R3: Each source i has a PRIO_W-bit priority register at address 16+i, which resets to 0 and reads back the written value. A source with priority 0 is never presented.
- R4: `irq` is high exactly when the highest priority among pending sources is strictly greater than the current priority. `vec_id` then names that source. Among equal priorities, the lowest index wins.
- R5: An `ack` sampled while `irq` is high pushes the current priority onto the stack and loads the presented source's priority as the new current priority. An `ack` while `irq` is low has no effect.
- R6: A write to address 1 (end of interrupt) pops the stack into the current priority. If the stack is empty, the write leaves the current priority unchanged and pulses `prio_err` for one cycle.
- R7: A write to address 0 sets the current priority from the low PRIO_W data bits when the stack is empty. While the stack is not empty, a value below the current priority is refused: the current priority is unchanged and `prio_err` pulses. A value at or above the current priority is accepted. Address 0 reads back the current priority.
- R8: The stack holds 2**PRIO_W entries. Handlers nested through every level from 1 to the maximum restore the levels in reverse order, and the stack never overflows.
- R9: When `ack` is taken in the same cycle as a write to address 0 or 1, the acknowledge takes effect and the write is dropped. Trigger-register and priority-register writes in that cycle still take effect.
- R10: After reset, the current priority is 0, the stack is empty, nothing is pending, all priorities are 0, and `irq` and `prio_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | NUM_HW | Level-sensitive hardware requests |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| ack | input | 1 | Processor takes the presented interrupt |
| irq | output | 1 | Interrupt request to the processor |
| vec_id | output | clog2(NUM_HW+NUM_SW) | Index of the presented source |
| prio_err | output | 1 | One-cycle pulse on a refused priority write or an empty-stack end of interrupt |

## Verification
The acknowledge path and the register bus both change the same state in one cycle. An `ack` can coincide with a current-priority write, an end-of-interrupt write, a trigger write or a priority write. The bench provokes this directly, by taking an interrupt while writing a lower current priority and while raising a new software request. It also provokes it at random, by driving `ack` and bus writes independently in every cycle. Each case is judged by the bench's model: the acknowledge wins over writes to addresses 0 and 1, while the pending flags and priorities take their writes as usual.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
   localparam int REG_CURP      = 0;
   localparam int REG_EOI       = 1;
   localparam int REG_SWTRIG    = 2;
   localparam int REG_PRIO_BASE = 16;

   typedef enum logic [1:0] {
      CP_HOLD,
      CP_PUSH,
      CP_POP,
      CP_LOAD
   } curp_op_e;
endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
   parameter int N  = 12,
   parameter int PW = 3,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]         req,
   input  logic [N-1:0][PW-1:0] pri,
   output logic [PW-1:0]        best_pri,
   output logic [IW-1:0]        best_idx
);
   // Strict comparison keeps the earliest index on ties; a zero level
   // can never beat the initial zero, so disabled sources drop out.
   always_comb begin
      best_pri = '0;
      best_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && (pri[i] > best_pri)) begin
            best_pri = pri[i];
            best_idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/intc_lifo.sv
module intc_lifo #(
   parameter int PW    = 3,
   parameter int DEPTH = 8,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [PW-1:0] din,
   output logic [PW-1:0] dout,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);
   logic [PW-1:0] mem_q [DEPTH];
   logic [CW-1:0] cnt_q;
   logic [AW-1:0] wr_idx;
   logic [AW-1:0] rd_idx;

   assign wr_idx = cnt_q[AW-1:0];
   assign rd_idx = wr_idx - AW'(1);
   assign empty  = (cnt_q == '0);
   assign full   = (cnt_q == CW'(DEPTH));
   assign count  = cnt_q;
   assign dout   = empty ? '0 : mem_q[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (push && !full) begin
         cnt_q <= cnt_q + CW'(1);
      end else if (pop && !empty) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem_q[g] <= '0;
            end else if (push && !full && (wr_idx == AW'(g))) begin
               mem_q[g] <= din;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/intc_swbank.sv
module intc_swbank #(
   parameter int NSW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic [NSW-1:0] set_mask,
   input  logic [NSW-1:0] clr_mask,
   output logic [NSW-1:0] pend
);
   generate
      for (genvar g = 0; g < NSW; g++) begin : g_src
         logic pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
            end else if (wr && set_mask[g]) begin
               pend_q <= 1'b1;
            end else if (wr && clr_mask[g]) begin
               pend_q <= 1'b0;
            end
         end
         assign pend[g] = pend_q;
      end
   endgenerate
endmodule

// File: rtl/prio_intc.sv
module prio_intc
   import prio_intc_pkg::*;
#(
   parameter int NUM_HW = 8,
   parameter int NUM_SW = 4,
   parameter int PRIO_W = 3,
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_HW-1:0]                   hw_req,
   input  logic                                bus_we,
   input  logic [ADDR_W-1:0]                   bus_addr,
   input  logic [DATA_W-1:0]                   bus_wdata,
   output logic [DATA_W-1:0]                   bus_rdata,
   input  logic                                ack,
   output logic                                irq,
   output logic [$clog2(NUM_HW+NUM_SW)-1:0]    vec_id,
   output logic                                prio_err
);
   localparam int NSRC  = NUM_HW + NUM_SW;
   localparam int IDX_W = $clog2(NSRC);
   localparam int DEPTH = 1 << PRIO_W;
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (NUM_HW < 1 || NUM_SW < 1) begin : g_bad_src
         $error("prio_intc: need at least one source of each kind");
      end
      if (DATA_W < 2 * NUM_SW || DATA_W < PRIO_W) begin : g_bad_dw
         $error("prio_intc: DATA_W too narrow for register fields");
      end
      if (REG_PRIO_BASE + NSRC > (1 << ADDR_W)) begin : g_bad_aw
         $error("prio_intc: ADDR_W too narrow for priority registers");
      end
      if (PRIO_W < 1 || PRIO_W > 6) begin : g_bad_pw
         $error("prio_intc: PRIO_W out of range");
      end
   endgenerate

   // ---------------- register decode ----------------
   logic hit_curp, hit_eoi, hit_swtrig;
   logic [NSRC-1:0] hit_prio;

   assign hit_curp   = bus_we && (bus_addr == ADDR_W'(REG_CURP));
   assign hit_eoi    = bus_we && (bus_addr == ADDR_W'(REG_EOI));
   assign hit_swtrig = bus_we && (bus_addr == ADDR_W'(REG_SWTRIG));

   // ---------------- per-source priorities ----------------
   logic [NSRC-1:0][PRIO_W-1:0] prio_q;

   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_prio
         assign hit_prio[g] = bus_we && (bus_addr == ADDR_W'(REG_PRIO_BASE + g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prio_q[g] <= '0;
            end else if (hit_prio[g]) begin
               prio_q[g] <= bus_wdata[PRIO_W-1:0];
            end
         end
      end
   endgenerate

   // ---------------- software sources ----------------
   logic [NUM_SW-1:0] sw_pend;

   intc_swbank #(.NSW(NUM_SW)) u_sw (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (hit_swtrig),
      .set_mask (bus_wdata[NUM_SW-1:0]),
      .clr_mask (bus_wdata[2*NUM_SW-1:NUM_SW]),
      .pend     (sw_pend)
   );

   // ---------------- arbitration ----------------
   logic [NSRC-1:0]   all_req;
   logic [PRIO_W-1:0] best_pri;
   logic [IDX_W-1:0]  best_idx;

   assign all_req = {sw_pend, hw_req};

   intc_arbiter #(.N(NSRC), .PW(PRIO_W)) u_arb (
      .req      (all_req),
      .pri      (prio_q),
      .best_pri (best_pri),
      .best_idx (best_idx)
   );

   // ---------------- current priority and stack ----------------
   logic [PRIO_W-1:0] curp_q;
   logic [PRIO_W-1:0] lifo_top;
   logic [CNT_W-1:0]  lifo_cnt;
   logic              lifo_empty, lifo_full;
   logic              take_ack, wr_cur, wr_eoi, cur_ok, err_d, err_q;
   curp_op_e          cp_op;

   assign irq      = (best_pri > curp_q);
   assign vec_id   = best_idx;
   assign take_ack = ack && irq;
   assign wr_cur   = hit_curp && !take_ack;
   assign wr_eoi   = hit_eoi && !take_ack;
   assign cur_ok   = lifo_empty || (bus_wdata[PRIO_W-1:0] >= curp_q);

   always_comb begin
      cp_op = CP_HOLD;
      err_d = 1'b0;
      if (take_ack) begin
         if (lifo_full) err_d = 1'b1;
         else           cp_op = CP_PUSH;
      end else if (wr_eoi) begin
         if (lifo_empty) err_d = 1'b1;
         else            cp_op = CP_POP;
      end else if (wr_cur) begin
         if (cur_ok) cp_op = CP_LOAD;
         else        err_d = 1'b1;
      end
   end

   intc_lifo #(.PW(PRIO_W), .DEPTH(DEPTH)) u_lifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (cp_op == CP_PUSH),
      .pop   (cp_op == CP_POP),
      .din   (curp_q),
      .dout  (lifo_top),
      .count (lifo_cnt),
      .empty (lifo_empty),
      .full  (lifo_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         curp_q <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= err_d;
         unique case (cp_op)
            CP_PUSH: curp_q <= best_pri;
            CP_POP:  curp_q <= lifo_top;
            CP_LOAD: curp_q <= bus_wdata[PRIO_W-1:0];
            default: curp_q <= curp_q;
         endcase
      end
   end

   assign prio_err = err_q;

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(REG_CURP)) begin
         bus_rdata[PRIO_W-1:0] = curp_q;
      end else if (bus_addr == ADDR_W'(REG_SWTRIG)) begin
         bus_rdata[2*NUM_SW-1:NUM_SW] = sw_pend;
      end
      for (int i = 0; i < NSRC; i++) begin
         if (bus_addr == ADDR_W'(REG_PRIO_BASE + i)) begin
            bus_rdata[PRIO_W-1:0] = prio_q[i];
         end
      end
   end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
   import prio_intc_pkg::*;
#(
   parameter int PRIO_W = 3,
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack,
   input logic              irq,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [PRIO_W-1:0] top_pri,
   input logic [PRIO_W-1:0] curp,
   input logic [CNT_W-1:0]  depth,
   input logic              prio_err
);
   localparam int DEPTH = 1 << PRIO_W;

   assert_present_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (top_pri > curp));

   assert_ack_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq && depth < CNT_W'(DEPTH)) |=>
         (depth == $past(depth) + 1'b1) && (curp == $past(top_pri)));

   assert_eoi_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(REG_EOI) && !(ack && irq) && depth != '0) |=>
         (depth == $past(depth) - 1'b1) && !prio_err);

   assert_refuse_lower_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(REG_CURP) && !(ack && irq) && depth != '0
         && bus_wdata[PRIO_W-1:0] < curp) |=> (prio_err && curp == $past(curp)));

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= CNT_W'(DEPTH));

   assert_ack_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq && bus_we && bus_addr == ADDR_W'(REG_CURP)) |=> (curp == $past(top_pri)));
endmodule

bind prio_intc prio_intc_chk #(
   .PRIO_W (PRIO_W),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ack       (ack),
   .irq       (irq),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .top_pri   (best_pri),
   .curp      (curp_q),
   .depth     (lifo_cnt),
   .prio_err  (prio_err)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
   localparam int NHW = 8, NSW = 4, PW = 3, AW = 6, DW = 8;
   localparam int NSRC = NHW + NSW, DEPTH = 1 << PW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NHW-1:0] hw_req = '0;
   logic bus_we = 1'b0, ack = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0, bus_rdata;
   logic irq, prio_err;
   logic [$clog2(NSRC)-1:0] vec_id;

   always #4 clk = ~clk;

   prio_intc #(.NUM_HW(NHW), .NUM_SW(NSW), .PRIO_W(PW), .ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack(ack), .irq(irq),
      .vec_id(vec_id), .prio_err(prio_err));

   int n_cmp = 0, n_bad = 0;
   bit finished = 1'b0;

   // reference model state
   logic [NSW-1:0] m_pend = '0;
   int m_prio [NSRC];
   int m_stk [DEPTH];
   int m_sp = 0, m_cur = 0;
   bit m_err = 1'b0;

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic void pick(input logic [NHW-1:0] hw, output int bi, output int bp);
      bi = 0; bp = 0;
      for (int i = 0; i < NSRC; i++) begin
         bit r;
         r = (i < NHW) ? hw[i] : m_pend[i-NHW];
         if (r && m_prio[i] > bp) begin bp = m_prio[i]; bi = i; end
      end
   endfunction

   task automatic step(input bit we, input int addr, input int data, input bit ak,
                       input logic [NHW-1:0] hw);
      int bi, bp;
      bit dack;
      @(negedge clk);
      bus_we = we; bus_addr = addr[AW-1:0]; bus_wdata = data[DW-1:0]; ack = ak; hw_req = hw;
      pick(hw, bi, bp);
      dack = ak && (bp > m_cur);
      @(posedge clk);
      #1;
      bus_we = 1'b0; ack = 1'b0;
      m_err = 1'b0;
      if (dack) begin
         if (m_sp < DEPTH) begin m_stk[m_sp] = m_cur; m_sp++; m_cur = bp; end
         else m_err = 1'b1;
      end else if (we && addr == 1) begin
         if (m_sp > 0) begin m_sp--; m_cur = m_stk[m_sp]; end
         else m_err = 1'b1;
      end else if (we && addr == 0) begin
         if (m_sp == 0 || (data % DEPTH) >= m_cur) m_cur = data % DEPTH;
         else m_err = 1'b1;
      end
      if (we && addr == 2)
         m_pend = (m_pend & ~data[2*NSW-1:NSW]) | data[NSW-1:0];
      if (we && addr >= 16 && addr < 16 + NSRC)
         m_prio[addr-16] = data % DEPTH;
   endtask

   task automatic check_all(input string tag);
      int bi, bp;
      pick(hw_req, bi, bp);
      cmp(tag, "irq", int'(irq), int'(bp > m_cur));
      if (bp > m_cur) cmp(tag, "vec_id", int'(vec_id), bi);
      cmp(tag, "prio_err", int'(prio_err), int'(m_err));
      bus_addr = AW'(0); #1;
      cmp(tag, "curp", int'(bus_rdata), m_cur);
      bus_addr = AW'(2); #1;
      cmp(tag, "swtrig", int'(bus_rdata), int'(m_pend) << NSW);
   endtask

   task automatic check_prio(input string tag, input int idx);
      bus_addr = AW'(16 + idx); #1;
      cmp(tag, "prio readback", int'(bus_rdata), m_prio[idx]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [NHW-1:0] hw;
      void'($urandom(32'd20240611));
      for (int i = 0; i < NSRC; i++) m_prio[i] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R10: reset state
      check_all("R10");
      check_prio("R10", 0);
      check_prio("R10", NSRC - 1);

      // R3: all lines high at priority 0 never present
      step(0, 0, 0, 0, '1); check_all("R3");
      step(1, 16 + 3, 5, 0, '1); check_prio("R3", 3); check_all("R3");
      step(1, 16 + 3, 0, 0, '0); check_all("R3");

      // R1/R2: trigger, write-0, set-and-clear, clear
      step(1, 2, 8'h02, 0, '0); check_all("R1");
      step(1, 2, 8'h00, 0, '0); check_all("R1");
      step(1, 2, 8'h11, 0, '0); check_all("R2");
      step(1, 2, 8'h20, 0, '0); check_all("R2");
      step(1, 2, 8'h10, 0, '0); check_all("R2");

      // R4: tie between hw 5 and sw 1 (index 9) at level 4 -> index 5
      step(1, 16 + 5, 4, 0, '0);
      step(1, 16 + 9, 4, 0, '0);
      step(0, 0, 0, 0, 8'h20); check_all("R4");
      step(0, 0, 0, 0, 8'h00); check_all("R4");
      step(1, 2, 8'h20, 0, '0);
      step(1, 2, 8'h02, 0, '0); check_all("R4");

      // R5: ack with irq low ignored; completion handshake on sw 1
      step(1, 2, 8'h20, 0, '0);
      step(0, 0, 0, 1, '0); check_all("R5");
      step(1, 2, 8'h02, 0, '0); check_all("R1");
      step(0, 0, 0, 1, '0); check_all("R5");
      check_all("R2");
      step(1, 2, 8'h20, 0, '0); check_all("R2");
      step(1, 1, 0, 0, '0); check_all("R6");
      step(1, 1, 0, 0, '0); check_all("R6");

      // R8: nest through every level on hw 0..6, with R7 and same-level probes
      for (int p = 1; p < DEPTH; p++) step(1, 16 + p - 1, p, 0, '0);
      step(1, 16 + 7, 3, 0, '0);
      hw = '0;
      for (int p = 1; p < DEPTH; p++) begin
         hw[p-1] = 1'b1;
         step(0, 0, 0, 0, hw); check_all("R8");
         step(0, 0, 0, 1, hw); check_all("R8");
         if (p == 3) begin
            step(0, 0, 0, 0, hw | 8'h80); check_all("R8");
            step(1, 0, 1, 0, hw); check_all("R7");
            step(1, 0, 3, 0, hw); check_all("R7");
         end
      end
      hw = '0;
      for (int p = 0; p < DEPTH; p++) begin step(1, 1, 0, 0, hw); check_all("R8"); end

      // R7: idle lowering accepted
      step(1, 0, 6, 0, '0); check_all("R7");
      step(1, 0, 0, 0, '0); check_all("R7");

      // R9: ack with curp write and with trigger write
      step(0, 0, 0, 0, 8'h10);
      step(1, 0, 0, 1, 8'h10); check_all("R9");
      step(1, 1, 0, 1, 8'h10); check_all("R9");
      step(1, 2, 8'h01, 1, 8'h40); check_all("R9");
      step(1, 1, 0, 0, '0); check_all("R9");
      step(1, 1, 0, 0, '0); check_all("R9");

      // random mix, all requirements
      for (int k = 0; k < 600; k++) begin
         int r, a, d;
         r = $urandom % 10;
         if (r < 3) a = 1;
         else if (r < 5) a = 0;
         else if (r < 7) a = 2;
         else a = 16 + ($urandom % NSRC);
         d = $urandom % 256;
         if (a == 0) d = $urandom % DEPTH;
         step(($urandom % 10) < 6, a, d, $urandom % 2,
              NHW'($urandom & $urandom & $urandom));
         check_all("R4");
      end

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule